// File: doc/BRIEF.md
# Scanline-Compare Interrupt Unit

This block follows the rendered lines of a video frame and raises an interrupt when the line count reaches a line number that the CPU has programmed. A pulse taken at dot 2 of every scanline advances the count. A separate frame-start pulse returns the count to zero at every frame boundary, whether or not rendering is enabled. A rendering-active input decides whether the block is inside a frame.

The CPU writes the target line through a small bus and reads a status byte on the same bus. The status byte shows whether an interrupt is pending and whether the block is inside a frame. Reading the status byte acknowledges the interrupt. The interrupt output is a level signal that stays high from the moment the interrupt becomes pending until that read.

Top module: `line_irq_top`

## Requirements
- R1: A synchronous active-high reset clears the line count, the target, the pending flag and the in-frame flag. After reset the IRQ output is low and the status byte reads 0x00.
- R2: The first line pulse seen while rendering is active sets the in-frame flag and loads the line count with 0. The in-frame flag appears as bit 6 of the status byte.
- R3: The in-frame flag clears on a frame-start pulse, and it also clears in any cycle in which rendering is inactive.
- R4: Each line pulse that arrives while in frame and with rendering active adds one to the count (modulo 256). If the new count equals the target, the interrupt becomes pending and the IRQ output goes high in the cycle after that clock edge.
- R5: A target value of 0 never makes the interrupt pending, even when the count wraps through 0.
- R6: A frame-start pulse resets the line count and the in-frame flag even while rendering is inactive, so the next frame counts from line 0.
- R7: A read at address 0x5204 returns bit 7 = pending, bit 6 = in-frame and bits 5..0 = 0. A read at any other address returns 0x00.
- R8: Once pending, the interrupt stays asserted until a status read at 0x5204 clears it. If a new match and a status read happen on the same edge, the interrupt stays pending.
- R9: A write at address 0x5203 loads the 8-bit target. Writes at other addresses leave the target unchanged. A match on the same edge as a target write uses the old target.
- R10: When a frame-start pulse and a line pulse arrive in the same cycle, the frame-start pulse wins: the count ends at 0 and the in-frame flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lineStart | input | 1 | One-cycle pulse at dot 2 of each scanline |
| frameStart | input | 1 | One-cycle pulse at each frame boundary |
| renderOn | input | 1 | High while rendering is active |
| cpuAddr | input | 16 | CPU bus address |
| cpuWrData | input | 8 | CPU write data |
| cpuWe | input | 1 | CPU write strobe |
| cpuRe | input | 1 | CPU read strobe |
| cpuRdData | output | 8 | CPU read data (combinational) |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default widths: an 8-bit count and target and a 16-bit address. With these widths a single directed frame of a few hundred lines takes the count all the way to target 255 and then through the wrap to 0, which exercises the never-fire rule for a zero target. Randomised frames also switch rendering off in the middle of a frame and move the target while counting is under way. They collide target writes, status reads and frame pulses with line pulses on the same edge, which exercises the priority and same-edge rules.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

  // Per-cycle strobes issued by the control to the datapath.
  typedef struct packed {
    logic frameClr;   // frame boundary: zero the count, leave frame
    logic enterFrame; // first line of a frame with rendering on
    logic advance;    // later line inside the frame
    logic leaveFrame; // rendering dropped while in frame
    logic tgtWrite;   // CPU loads the target line
    logic statusRead; // CPU reads the status byte
  } lineStrobes_t;

endpackage

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              renderOn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic              inFrame,
  output lineStrobes_t      strobes
);

  logic lineLive;

  // A line pulse counts only while rendering and outside a frame boundary.
  assign lineLive = lineStart && renderOn && !frameStart;

  always_comb begin
    strobes            = '0;
    strobes.frameClr   = frameStart;
    strobes.enterFrame = lineLive && !inFrame;
    strobes.advance    = lineLive && inFrame;
    strobes.leaveFrame = !frameStart && !renderOn && inFrame;
    strobes.tgtWrite   = cpuWe && (cpuAddr == TARGET_ADDR);
    strobes.statusRead = cpuRe && (cpuAddr == STATUS_ADDR);
  end

  // R10: at most one frame-tracking event per cycle, frame start taking precedence
  assert_event_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.frameClr, strobes.enterFrame, strobes.advance, strobes.leaveFrame}));

endmodule

// File: rtl/line_irq_dp.sv
module line_irq_dp
  import line_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lineStrobes_t      strobes,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic              inFrame,
  output logic              pending,
  output logic [DATA_W-1:0] statusByte
);

  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] lineCount;
  logic [DATA_W-1:0] targetLine;
  logic [DATA_W-1:0] nextCount;
  logic              matchHit;

  assign nextCount = lineCount + DATA_W'(1);
  assign matchHit  = strobes.advance && (nextCount == targetLine) &&
                     (targetLine != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCount <= '0;
    end else if (strobes.frameClr || strobes.enterFrame) begin
      lineCount <= '0;
    end else if (strobes.advance) begin
      lineCount <= nextCount;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inFrame <= 1'b0;
    end else if (strobes.frameClr || strobes.leaveFrame) begin
      inFrame <= 1'b0;
    end else if (strobes.enterFrame) begin
      inFrame <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      targetLine <= '0;
    end else if (strobes.tgtWrite) begin
      targetLine <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (matchHit) begin
      pending <= 1'b1;
    end else if (strobes.statusRead) begin
      pending <= 1'b0;
    end
  end

  assign statusByte = {pending, inFrame, {PAD_W{1'b0}}};

  assert_enter_frame_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.enterFrame |=> (inFrame && lineCount == '0));

  assert_leave_frame_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.leaveFrame |=> !inFrame);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> (lineCount == $past(lineCount) + DATA_W'(1)));

  assert_zero_target_R5: assert property (@(posedge clk) disable iff (rst)
    (targetLine == '0 && !pending) |=> !pending);

  assert_frame_reset_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.frameClr |=> (lineCount == '0 && !inFrame));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pending && !strobes.statusRead) |=> pending);

  assert_read_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.statusRead && !matchHit) |=> !pending);

  assert_target_keep_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.tgtWrite |=> $stable(targetLine));

endmodule

// File: rtl/line_irq_top.sv
module line_irq_top
  import line_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              renderOn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWe,
  input  logic              cpuRe,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              irqOut
);

  lineStrobes_t      strobes;
  logic              inFrame;
  logic              pending;
  logic [DATA_W-1:0] statusByte;

  line_irq_ctrl #(
    .ADDR_W     (ADDR_W),
    .TARGET_ADDR(TARGET_ADDR),
    .STATUS_ADDR(STATUS_ADDR)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .lineStart (lineStart),
    .frameStart(frameStart),
    .renderOn  (renderOn),
    .cpuAddr   (cpuAddr),
    .cpuWe     (cpuWe),
    .cpuRe     (cpuRe),
    .inFrame   (inFrame),
    .strobes   (strobes)
  );

  line_irq_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .cpuWrData (cpuWrData),
    .inFrame   (inFrame),
    .pending   (pending),
    .statusByte(statusByte)
  );

  assign cpuRdData = strobes.statusRead ? statusByte : '0;
  assign irqOut    = pending;

  // R7: a status read reports the level presently on the IRQ line in bit 7
  assert_status_irq_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.statusRead |-> (cpuRdData[DATA_W-1] == irqOut));

  // R1: the cycle after reset shows no interrupt
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !irqOut);

endmodule

// File: tb/line_irq_top_tb_top.sv
`timescale 1ns/1ps
module line_irq_top_tb_top;

  localparam logic [15:0] TGT = 16'h5203;
  localparam logic [15:0] STA = 16'h5204;

  logic        clk = 1'b0;
  logic        rst;
  logic        lineStart, frameStart, renderOn, cpuWe, cpuRe;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWrData, cpuRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mCount, mTarget;
  logic       mPend, mIn;

  always #2.5 clk = ~clk;

  line_irq_top dut_i (
    .clk(clk), .rst(rst), .lineStart(lineStart), .frameStart(frameStart),
    .renderOn(renderOn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuRdData(cpuRdData), .irqOut(irqOut)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expStatus(logic [15:0] a);
    return (a == STA) ? {mPend, mIn, 6'b0} : 8'h00;
  endfunction

  task automatic modelStep(logic ls, logic fs, logic ro, logic we, logic re,
                           logic [15:0] a, logic [7:0] d);
    logic hit;
    logic [7:0] nc;
    hit = 1'b0;
    nc = mCount + 8'd1;
    if (fs) begin
      mCount = 8'd0; mIn = 1'b0;
    end else if (ls && ro && !mIn) begin
      mCount = 8'd0; mIn = 1'b1;
    end else if (ls && ro && mIn) begin
      hit = (nc == mTarget) && (mTarget != 8'd0);
      mCount = nc;
    end else if (!ro) begin
      mIn = 1'b0;
    end
    if (hit) mPend = 1'b1;
    else if (re && a == STA) mPend = 1'b0;
    if (we && a == TGT) mTarget = d;
  endtask

  // One clock: drive at negedge, check reads before the edge, irq after it.
  task automatic tick(logic ls, logic fs, logic ro, logic we, logic re,
                      logic [15:0] a, logic [7:0] d);
    lineStart = ls; frameStart = fs; renderOn = ro;
    cpuWe = we; cpuRe = re; cpuAddr = a; cpuWrData = d;
    #1;
    if (re) chk("R7", cpuRdData, expStatus(a));
    @(posedge clk);
    modelStep(ls, fs, ro, we, re, a, d);
    @(negedge clk);
    chk("R4", {7'd0, irqOut}, {7'd0, mPend});
    lineStart = 0; frameStart = 0; cpuWe = 0; cpuRe = 0;
  endtask

  task automatic idle(int n, logic ro);
    for (int i = 0; i < n; i++) tick(0, 0, ro, 0, 0, 16'h0, 8'h0);
  endtask

  task automatic wrTarget(logic [15:0] a, logic [7:0] d);
    tick(0, 0, renderOn, 1, 0, a, d);
  endtask

  task automatic readStatus();
    tick(0, 0, renderOn, 0, 1, STA, 8'h0);
  endtask

  task automatic line(logic ro);
    tick(1, 0, ro, 0, 0, 16'h0, 8'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedV;
    seedV = $urandom(32'h00005eed);
    mCount = 0; mTarget = 0; mPend = 0; mIn = 0;
    rst = 1; lineStart = 0; frameStart = 0; renderOn = 0;
    cpuWe = 0; cpuRe = 0; cpuAddr = 0; cpuWrData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1", {7'd0, irqOut}, 8'd0);
    readStatus();
    chk("R1", cpuRdData, 8'h00);

    // R9: a write elsewhere does not load the target
    renderOn = 1;
    wrTarget(16'h5202, 8'd2);
    wrTarget(TGT, 8'd3);
    wrTarget(16'h5213, 8'd1);
    tick(0, 1, 1, 0, 0, 16'h0, 8'h0);
    line(1); idle(1, 1);
    // R2: in-frame visible in status
    tick(0, 0, 1, 0, 1, STA, 8'h0);
    chk("R2", {7'd0, mIn}, 8'd1);
    line(1); idle(1, 1);
    line(1); idle(1, 1);
    chk("R9", {7'd0, irqOut}, 8'd0);
    line(1);
    chk("R4", {7'd0, irqOut}, 8'd1);
    // R8: stays high until read
    idle(5, 1);
    chk("R8", {7'd0, irqOut}, 8'd1);
    tick(0, 0, 1, 0, 1, 16'h5205, 8'h0);
    chk("R8", {7'd0, irqOut}, 8'd1);
    readStatus();
    chk("R8", {7'd0, irqOut}, 8'd0);

    // R3: rendering off drops in-frame
    tick(0, 0, 0, 0, 1, STA, 8'h0);
    readStatus();
    chk("R3", cpuRdData, 8'h00);

    // R6: frame reset with rendering off
    renderOn = 1;
    wrTarget(TGT, 8'd2);
    tick(0, 1, 1, 0, 0, 16'h0, 8'h0);
    line(1); line(1); // count 0 then 1
    tick(0, 1, 0, 0, 0, 16'h0, 8'h0); // frame start while off
    line(0);
    line(1); line(1);
    chk("R6", {7'd0, irqOut}, 8'd0);
    line(1);
    chk("R6", {7'd0, irqOut}, 8'd1);

    // R8: match and read on the same edge keeps pending
    readStatus();
    wrTarget(TGT, 8'd3);
    tick(1, 0, 1, 0, 1, STA, 8'h0);
    chk("R8", {7'd0, irqOut}, 8'd1);
    readStatus();

    // R10: frame start wins over a line pulse
    tick(1, 1, 1, 0, 0, 16'h0, 8'h0);
    readStatus();
    chk("R10", cpuRdData, 8'h00);

    // R5 and wrap: target 255 then target 0 through the wrap
    wrTarget(TGT, 8'd255);
    tick(0, 1, 1, 0, 0, 16'h0, 8'h0);
    for (int i = 0; i < 255; i++) line(1);
    chk("R4", {7'd0, irqOut}, 8'd0);
    line(1);
    chk("R4", {7'd0, irqOut}, 8'd1);
    readStatus();
    wrTarget(TGT, 8'd0);
    for (int i = 0; i < 300; i++) line(1);
    chk("R5", {7'd0, irqOut}, 8'd0);

    // Constrained random frames
    for (int f = 0; f < 12; f++) begin
      wrTarget(TGT, ($urandom % 6 == 0) ? 8'd0 : 8'($urandom % 40));
      tick(0, 1, ($urandom % 4 != 0), 0, 0, 16'h0, 8'h0);
      for (int l = 0; l < 50; l++) begin
        logic ro;
        ro = ($urandom % 20 != 0);
        tick(1, ($urandom % 97 == 0), ro, ($urandom % 25 == 0),
             ($urandom % 5 == 0), ($urandom % 2) ? STA : TGT, 8'($urandom % 40));
        for (int k = 0; k < 2; k++)
          tick(0, 0, ro, 0, ($urandom % 3 == 0),
               ($urandom % 4 == 0) ? 16'h5200 : STA, 8'h0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule